// File: doc/BRIEF.md
# Mode-Selectable Decimating Downconverter

This block takes one stream of signed 14-bit converter samples, each marked by a valid strobe, and produces a reduced-rate stream. It has three modes. Pass-through forwards every sample at the full rate. The real path low-pass filters the stream and keeps one sample in M. The complex path first mixes the stream to baseband with an internal numerically controlled oscillator, then filters and decimates the I and Q branches.

The decimation factor M is 8 or 16. The filter spans 4·M taps, so going from 8 to 16 doubles its length and halves its corner. The taps are fixed inside the block and follow from the factor alone. The complex path keeps roughly 80 percent of fs/M as useful band. The real path keeps half of that: at 2 GS/s with M = 8 that is 100 MHz.

Whenever the mode or the factor changes, the block discards its history. In that same cycle it restarts its output grid and its oscillator phase.

Top module: `mode_ddc`

## Requirements
- R1: While reset is held, out_valid is 0 and out_i and out_q are 0.
- R2: In pass-through mode, every accepted sample appears one cycle later with out_valid high, out_i the sign-extended sample and out_q 0.
- R3: In real mode, no mixing takes place. The filter input on the I branch is the raw sample, and out_q is 0 on every real-mode output.
- R4: In complex mode, the oscillator phase is 32 bits and starts at 0. It advances by nco_step after each accepted sample. Its top 4 bits select one of 16 points of S(k) = round(32767·sin(2πk/16)), with the cosine taken as S(k+4). The filter inputs are I = (x·S(k+4)) >>> 15 and Q = (x·(−S(k))) >>> 15.
- R5: The filter has L = 4·M taps with weights h(k) = (k+1)·(L−k) for k = 0…L−1. M is 8 when dec16 = 0 and 16 when dec16 = 1. Each output equals Σ h(k)·u(n−k), where u is the branch input and samples from before the last flush count as 0.
- R6: In a decimating mode, outputs come only on accepted samples whose index n, counted from 0 since the last flush, satisfies n mod M = M−1. Each such output appears one cycle after that sample, so there is exactly one output per M accepted samples.
- R7: Each filter sum is rounded by adding 2^(SH−1) and shifting arithmetically right by SH, with SH = 10 for M = 8 and SH = 13 for M = 16. The result then saturates to the range −32768…32767.
- R8: A change of mode or dec16 from one cycle to the next empties the filter history, restarts the sample index at 0 and resets the oscillator phase to 0. A sample accepted in that cycle is the first sample of the new setting.
- R9: Mode encoding: 0 is pass-through, 1 is real, 2 is complex, and 3 behaves as pass-through.
- R10: Cycles with in_valid low change neither the sample index nor the oscillator phase nor the filter state. They raise no output, and out_i and out_q hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 0 pass-through, 1 real, 2 complex, 3 pass-through |
| dec16 | input | 1 | 0 selects M = 8, 1 selects M = 16 |
| nco_step | input | 32 | Oscillator phase increment per accepted sample |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 14 | Signed input sample |
| out_valid | output | 1 | Output strobe |
| out_i | output | 16 | Signed I (or pass-through / real) output |
| out_q | output | 16 | Signed Q output, 0 outside complex mode |

## Verification
Every result is registered once. An output, whether passed through or decimated, is due on the clock edge that follows the edge accepting its sample. A setting change takes effect on the edge where it is first presented. The bench drives inputs on the falling edge. Its reference model then predicts what the next rising edge will show, and the prediction is compared with the ports on the following falling edge, one full cycle after the stimulus, in every cycle including reset and idle cycles.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,
    MODE_REAL  = 2'd1,
    MODE_CPLX  = 2'd2,
    MODE_SPARE = 2'd3
  } ddc_mode_e;

  // Parabolic low-pass weight; symmetric over a window of len taps.
  function automatic int window_coef(int pos, int len);
    return (pos + 1) * (len - pos);
  endfunction

  // 16-point sine, full scale 32767.
  function automatic int wave_sample(logic [3:0] idx);
    int mag;
    case (idx[2:0])
      3'd0:    mag = 0;
      3'd1:    mag = 12539;
      3'd2:    mag = 23170;
      3'd3:    mag = 30273;
      3'd4:    mag = 32767;
      3'd5:    mag = 30273;
      3'd6:    mag = 23170;
      default: mag = 12539;
    endcase
    return idx[3] ? -mag : mag;
  endfunction

  // Round half up by sh bits, then clamp to a signed ow-bit range.
  function automatic longint round_sat(longint v, int sh, int ow);
    longint r, hi, lo;
    r  = (v + (longint'(1) <<< (sh - 1))) >>> sh;
    hi = (longint'(1) <<< (ow - 1)) - 1;
    lo = -hi - 1;
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r;
  endfunction

endpackage

// File: rtl/ddc_nco.sv
module ddc_nco import ddc_pkg::*; #(
  parameter int PH_W  = 32,
  parameter int MIX_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fresh,
  input  logic                    adv,
  input  logic [PH_W-1:0]         step,
  output logic signed [MIX_W-1:0] cos_o,
  output logic signed [MIX_W-1:0] sin_o
);
  localparam int IDX_W = 4;

  logic [PH_W-1:0]  phase_q;
  logic [PH_W-1:0]  phase_e;
  logic [IDX_W-1:0] idx;

  assign phase_e = fresh ? '0 : phase_q;
  assign idx     = phase_e[PH_W-1 -: IDX_W];
  assign cos_o   = MIX_W'(wave_sample(idx + 4'd4));
  assign sin_o   = MIX_W'(wave_sample(idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase_q <= '0;
    else if (adv)   phase_q <= phase_e + step;
    else if (fresh) phase_q <= '0;
  end

  // R10: an idle cycle without a setting change leaves the phase alone
  assert_phase_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !fresh) |=> $stable(phase_q));

endmodule

// File: rtl/ddc_polyfir.sv
module ddc_polyfir import ddc_pkg::*; #(
  parameter int D_W       = 16,
  parameter int COEF_W    = 16,
  parameter int ACC_W     = 40,
  parameter int OUT_W     = 16,
  parameter int SPAN      = 4,
  parameter int LOGM_MIN  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fresh,
  input  logic                    take,
  input  logic                    dec16,
  input  logic signed [D_W-1:0]   din,
  output logic                    dump_o,
  output logic signed [OUT_W-1:0] res_o
);
  localparam int PROD_W = D_W + COEF_W;
  localparam int CNT_W  = LOGM_MIN + 1 + $clog2(SPAN);
  localparam int SH_LO  = 3 * LOGM_MIN + 1;

  logic [CNT_W-1:0]        cnt_q, cnt_e;
  int                      m_len, len_i, sh;
  logic signed [ACC_W-1:0] sum_w [SPAN];
  logic [SPAN-1:0]         end_w;
  logic signed [ACC_W-1:0] sel;

  assign m_len = dec16 ? (1 << (LOGM_MIN + 1)) : (1 << LOGM_MIN);
  assign len_i = SPAN * m_len;
  assign sh    = dec16 ? SH_LO + 3 : SH_LO;
  assign cnt_e = fresh ? '0 : cnt_q;

  // One accumulator per overlapping window; windows end M samples apart.
  for (genvar j = 0; j < SPAN; j++) begin : g_win
    logic signed [ACC_W-1:0]  acc_q, acc_e;
    logic signed [COEF_W-1:0] coef_w;
    logic signed [PROD_W-1:0] prod_w;
    int pos;

    always_comb begin
      pos = int'(cnt_e) + len_i - (j + 1) * m_len;
      if (pos >= len_i) pos = pos - len_i;
    end

    assign coef_w   = COEF_W'(window_coef(pos, len_i));
    assign acc_e    = fresh ? '0 : acc_q;
    assign prod_w   = din * coef_w;
    assign sum_w[j] = acc_e + {{(ACC_W-PROD_W){prod_w[PROD_W-1]}}, prod_w};
    assign end_w[j] = (pos == len_i - 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q <= '0;
      else if (take)  acc_q <= end_w[j] ? '0 : sum_w[j];
      else if (fresh) acc_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (take)  cnt_q <= (int'(cnt_e) == len_i - 1) ? '0 : cnt_e + 1'b1;
    else if (fresh) cnt_q <= '0;
  end

  always_comb begin
    sel = '0;
    for (int k = 0; k < SPAN; k++)
      if (end_w[k]) sel = sum_w[k];
  end

  assign dump_o = take && ((int'(cnt_e) & (m_len - 1)) == m_len - 1);
  assign res_o  = OUT_W'(round_sat(longint'(sel), sh, OUT_W));

  // R6: a dump closes exactly one window
  assert_one_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dump_o |-> ($countones(end_w) == 1));

  // R6: after a dump the index sits on an M boundary
  assert_decim_grid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dump_o |=> ((int'(cnt_q) & ($past(dec16) ? 15 : 7)) == 0));

  // R8: a setting change restarts the index
  assert_flush_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |=> (cnt_q == ($past(take) ? CNT_W'(1) : CNT_W'(0))));

endmodule

// File: rtl/mode_ddc.sv
module mode_ddc import ddc_pkg::*; #(
  parameter int IN_W   = 14,
  parameter int OUT_W  = 16,
  parameter int MIX_W  = 16,
  parameter int COEF_W = 16,
  parameter int PH_W   = 32,
  parameter int ACC_W  = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             dec16,
  input  logic [PH_W-1:0]  nco_step,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_i,
  output logic [OUT_W-1:0] out_q
);
  localparam int FRAC   = MIX_W - 1;
  localparam int MPROD  = IN_W + MIX_W;
  localparam int BRANCH = 2;

  ddc_mode_e               mode_e;
  logic [2:0]              cfg_q;
  logic                    fresh, cplx, decim, take, adv, dump_any;
  logic signed [IN_W-1:0]  x;
  logic signed [MIX_W-1:0] cos_w, sin_w, nsin_w;
  logic signed [MPROD-1:0] pi_w, pq_w;
  logic signed [MIX_W-1:0] mix_w  [BRANCH];
  logic signed [OUT_W-1:0] res_w  [BRANCH];
  logic                    dump_w [BRANCH];

  assign mode_e = ddc_mode_e'(mode);
  assign fresh  = ({mode, dec16} != cfg_q);
  assign cplx   = (mode_e == MODE_CPLX);
  assign decim  = cplx || (mode_e == MODE_REAL);
  assign take   = in_valid && decim;
  assign adv    = in_valid && cplx;
  assign x      = $signed(in_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= {MODE_PASS, 1'b0};
    else        cfg_q <= {mode, dec16};
  end

  ddc_nco #(.PH_W(PH_W), .MIX_W(MIX_W)) u_nco (
    .clk(clk), .rst_n(rst_n), .fresh(fresh), .adv(adv),
    .step(nco_step), .cos_o(cos_w), .sin_o(sin_w)
  );

  assign nsin_w   = -sin_w;
  assign pi_w     = x * cos_w;
  assign pq_w     = x * nsin_w;
  assign mix_w[0] = cplx ? MIX_W'(pi_w >>> FRAC) : MIX_W'(x);
  assign mix_w[1] = cplx ? MIX_W'(pq_w >>> FRAC) : '0;

  for (genvar b = 0; b < BRANCH; b++) begin : g_br
    ddc_polyfir #(
      .D_W(MIX_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .OUT_W(OUT_W),
      .SPAN(4), .LOGM_MIN(3)
    ) u_fir (
      .clk(clk), .rst_n(rst_n), .fresh(fresh), .take(take), .dec16(dec16),
      .din(mix_w[b]), .dump_o(dump_w[b]), .res_o(res_w[b])
    );
  end

  assign dump_any = dump_w[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else if (!decim) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_i <= OUT_W'(x);
        out_q <= '0;
      end
    end else begin
      out_valid <= dump_any;
      if (dump_any) begin
        out_i <= res_w[0];
        out_q <= res_w[1];
      end
    end
  end

  // R2: every pass-through sample yields an output next cycle
  assert_bypass_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !decim) |=> out_valid);

  // R3: real-mode results carry no quadrature part
  assert_real_q_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_any && mode_e == MODE_REAL) |=> (out_q == '0));

  // R10: no output without an accepted sample
  assert_valid_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R6: both branches keep the same output grid
  assert_branch_lockstep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dump_w[0] == dump_w[1]);

endmodule

// File: tb/sim_mode_ddc.sv
module sim_mode_ddc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        dec16 = 1'b0;
  logic [31:0] nco_step = '0;
  logic        in_valid = 1'b0;
  logic [13:0] in_data = '0;
  logic        out_valid;
  logic [15:0] out_i, out_q;

  int checks = 0;
  int fails  = 0;

  logic        exp_v = 1'b0;
  logic [15:0] exp_i = '0;
  logic [15:0] exp_q = '0;
  string       exp_tag = "R1";

  int          hi[$];
  int          hq[$];
  logic [31:0] m_phase = '0;
  int          m_n = 0;
  int          m_mode_prev = 0;
  bit          m_dec_prev = 1'b0;

  always #2 clk = ~clk;

  mode_ddc u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .dec16(dec16), .nco_step(nco_step),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  function automatic int tab_sin(int k);
    real v;
    v = 32767.0 * $sin(6.283185307179586 * k / 16.0);
    return $rtoi($floor(v + 0.5));
  endfunction

  function automatic longint ref_out(int q[$], int mm, bit d16);
    longint acc = 0;
    longint r;
    int len = 4 * mm;
    int sh = d16 ? 13 : 10;
    for (int k = 0; k < len && k < q.size(); k++)
      acc += longint'(k + 1) * longint'(len - k) * longint'(q[k]);
    r = (acc + (longint'(1) << (sh - 1))) >>> sh;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic check_out();
    checks++;
    if (out_valid !== exp_v || out_i !== exp_i || out_q !== exp_q) begin
      fails++;
      $display("FAIL %s: got valid=%b i=%0d q=%0d, expected valid=%b i=%0d q=%0d",
               exp_tag, out_valid, $signed(out_i), $signed(out_q),
               exp_v, $signed(exp_i), $signed(exp_q));
    end
  endtask

  task automatic model(int md, bit d16, bit v, int x, logic [31:0] stp, string tag);
    int mi, mq, mm, idx;
    if (md != m_mode_prev || d16 != m_dec_prev) begin
      hi.delete();
      hq.delete();
      m_phase = '0;
      m_n = 0;
    end
    m_mode_prev = md;
    m_dec_prev  = d16;
    exp_v = 1'b0;
    if (v) begin
      if (md == 1 || md == 2) begin
        if (md == 2) begin
          idx = int'(m_phase[31:28]);
          mi = (x * tab_sin((idx + 4) % 16)) >>> 15;
          mq = (x * (-tab_sin(idx))) >>> 15;
          m_phase = m_phase + stp;
        end else begin
          mi = x;
          mq = 0;
        end
        hi.push_front(mi);
        hq.push_front(mq);
        if (hi.size() > 64) begin
          void'(hi.pop_back());
          void'(hq.pop_back());
        end
        mm = d16 ? 16 : 8;
        if (m_n % mm == mm - 1) begin
          exp_v   = 1'b1;
          exp_i   = 16'(ref_out(hi, mm, d16));
          exp_q   = 16'(ref_out(hq, mm, d16));
          exp_tag = tag;
        end
        m_n++;
      end else begin
        exp_v   = 1'b1;
        exp_i   = 16'(x);
        exp_q   = '0;
        exp_tag = tag;
      end
    end
  endtask

  task automatic tick(int md, bit d16, bit v, int x, logic [31:0] stp, string tag);
    check_out();
    if (!exp_v) exp_tag = tag;
    model(md, d16, v, x, stp, tag);
    mode     = 2'(md);
    dec16    = d16;
    in_valid = v;
    in_data  = 14'(x);
    nco_step = stp;
    @(negedge clk);
  endtask

  function automatic int rnd14();
    return int'($urandom % 16384) - 8192;
  endfunction

  initial begin
    #(4 * 50000);
    fails++;
    $display("FAIL watchdog: run incomplete, expected finish before cycle limit");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    for (int k = 0; k < 3; k++) tick(0, 0, 0, 0, 0, "R1");
    rst_n = 1'b1;

    // R2: pass-through, edge values, with gaps (R10 on idle cycles)
    for (int k = 0; k < 24; k++) begin
      int xv = (k == 3) ? -8192 : (k == 4) ? 8191 : k * 301 - 3000;
      tick(0, 0, (k % 5) != 2, xv, 0, "R2");
    end
    // R9: spare code behaves as pass-through
    for (int k = 0; k < 10; k++) tick(3, 0, 1, 1234 - k * 777, 0, "R9");

    // R3: real M=8, DC input with gaps
    for (int k = 0; k < 80; k++) tick(1, 0, (k % 9) != 4, 4000, 0, "R3");
    // R5: real M=8 alternating input, then real M=16 random
    for (int k = 0; k < 64; k++) tick(1, 0, 1, (k % 2) ? 8000 : -8000, 0, "R5");
    for (int k = 0; k < 200; k++) tick(1, 1, 1, rnd14(), 0, "R5");
    // R6: real M=16 ramp, every cycle valid
    for (int k = 0; k < 96; k++) tick(1, 1, 1, k * 150 - 7000, 0, "R6");

    // R7: saturation both ways
    for (int k = 0; k < 48; k++) tick(1, 0, 1, 8191, 0, "R7");
    tick(0, 0, 0, 0, 0, "R7");
    for (int k = 0; k < 48; k++) tick(1, 0, 1, -8192, 0, "R7");

    // R4: complex M=8 at fs/16, then M=16 random with a different step
    for (int k = 0; k < 150; k++) tick(2, 0, (k % 11) != 5, 6000, 32'h1000_0000, "R4");
    for (int k = 0; k < 300; k++) tick(2, 1, (k % 13) != 7, rnd14(), 32'h0345_6789, "R4");

    // R10: sparse samples in real M=8
    for (int k = 0; k < 120; k++) tick(1, 0, (k % 3) == 0, rnd14(), 0, "R10");

    // R8: flush in mid-window, by factor and by mode during an idle cycle
    for (int k = 0; k < 13; k++) tick(1, 0, 1, rnd14(), 0, "R8");
    for (int k = 0; k < 40; k++) tick(1, 1, 1, rnd14(), 0, "R8");
    tick(2, 1, 0, 0, 32'h0badc0de, "R8");
    for (int k = 0; k < 70; k++) tick(2, 1, 1, rnd14(), 32'h0badc0de, "R8");
    for (int k = 0; k < 5; k++) tick(2, 0, 1, rnd14(), 32'h0badc0de, "R8");
    for (int k = 0; k < 40; k++) tick(2, 0, 1, 5000, 32'h0badc0de, "R8");
    for (int k = 0; k < 4; k++) tick(0, 0, 0, 0, 0, "R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule